// File: doc/BRIEF.md
# Pausing Parent-Child Repeat Controller

This block sequences a fixed static schedule in two levels. A parent counter steps through a fixed number of states, one per cycle. At one chosen state the parent stops counting and passes control to a child counter, which runs a loop body of fixed latency. An iteration counter records how many passes of the body have finished. When the last pass ends, the child and iteration counters clear and the parent moves to its next state in the same cycle.

The three counter values are brought out so that guard logic elsewhere can decode them and enable the datapath actions of each schedule slot. A start pulse launches the schedule while the block is idle. A one-cycle done pulse marks the end. Because the parent holds still during the loop, its width depends only on the number of parent states. The loop length does not add to it.

The parameters are the parent length, the offload state, the body latency and the repeat count. The default values give 21 parent states, offload at state 5, a 5-cycle body and 10 repeats. With these values done rises 70 cycles after start is accepted.

Top module: `repeat_sched`

## Requirements
- R1: After reset `active` and `done` are 0 and `parentState`, `childStep` and `iterIdx` are all 0.
- R2: When `start` is 1 at a rising edge while `active` is 0, the block sets `active` to 1 from that edge, with `parentState` at 0.
- R3: While active, at any parent state other than OFFLOAD_AT and PARENT_LEN-1, `parentState` increases by exactly one on every edge.
- R4: While `parentState` equals OFFLOAD_AT, it holds that value until the final pass of the body completes.
- R5: During the offload, `childStep` counts 0 to BODY_LAT-1 and wraps to 0. On each wrap that is not the last one, `iterIdx` increases by one.
- R6: On the edge where `childStep` is BODY_LAT-1 and `iterIdx` is REPEATS-1, both counters return to 0 and `parentState` becomes OFFLOAD_AT+1 on the same edge.
- R7: `done` is 1 for exactly one cycle, (PARENT_LEN-1)+BODY_LAT*REPEATS edges after the edge that accepted start. With the default values that is 70 edges. On that same edge `active` falls and all counters are 0.
- R8: `start` asserted while `active` is 1 has no effect on the counter trajectory or on when done occurs.
- R9: `childStep` and `iterIdx` are 0 whenever the block is idle or `parentState` is not OFFLOAD_AT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only while idle |
| done | output | 1 | One-cycle pulse when the schedule ends |
| active | output | 1 | Schedule in progress |
| parentState | output | PW | Parent counter value |
| childStep | output | CW | Body step within the current pass |
| iterIdx | output | IW | Index of the current pass |

## Verification
The hardest point to reach is the single edge that ends the loop. At that edge the child wraps on the last pass, both loop counters clear and the parent moves on, all together. A retrigger that lands inside the offload must also leave that exit unchanged. The bench runs the whole schedule and compares every cycle against a model that computes the three counter values from the elapsed cycle count. It then repeats the run while it pulses start before the offload, in the middle of the loop, on the exact exit cycle and on the final state. It expects the same trajectory each time.

// File: rtl/repeat_sched_pkg.sv
package repeat_sched_pkg;

  typedef struct packed {
    logic parentInc;
    logic parentClr;
    logic childInc;
    logic childClr;
    logic iterInc;
    logic iterClr;
    logic finish;
  } sched_strobe_t;

  typedef struct packed {
    logic atOffload;
    logic atLast;
    logic childWrap;
    logic iterLast;
  } sched_status_t;

  function automatic int cntWidth(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sched_counter.sv
module sched_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    value <= '0;
    else if (clr) value <= '0;
    else if (inc) value <= value + W'(1);
  end

endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import repeat_sched_pkg::*;
#(
  parameter int PARENT_LEN = 21,
  parameter int OFFLOAD_AT = 5,
  parameter int BODY_LAT   = 5,
  parameter int REPEATS    = 10,
  localparam int PW = cntWidth(PARENT_LEN),
  localparam int CW = cntWidth(BODY_LAT),
  localparam int IW = cntWidth(REPEATS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  sched_strobe_t strobe,
  output sched_status_t status,
  output logic [PW-1:0] parentCnt,
  output logic [CW-1:0] childCnt,
  output logic [IW-1:0] iterCnt
);

  localparam logic [PW-1:0] OffState  = PW'(OFFLOAD_AT);
  localparam logic [PW-1:0] LastState = PW'(PARENT_LEN - 1);
  localparam logic [CW-1:0] LastStep  = CW'(BODY_LAT - 1);
  localparam logic [IW-1:0] LastIter  = IW'(REPEATS - 1);

  sched_counter #(.W(PW)) parentCtr (
    .clk(clk), .rstN(rstN),
    .inc(strobe.parentInc), .clr(strobe.parentClr), .value(parentCnt)
  );

  sched_counter #(.W(CW)) childCtr (
    .clk(clk), .rstN(rstN),
    .inc(strobe.childInc), .clr(strobe.childClr), .value(childCnt)
  );

  sched_counter #(.W(IW)) iterCtr (
    .clk(clk), .rstN(rstN),
    .inc(strobe.iterInc), .clr(strobe.iterClr), .value(iterCnt)
  );

  always_comb begin
    status.atOffload = (parentCnt == OffState);
    status.atLast    = (parentCnt == LastState);
    status.childWrap = (childCnt == LastStep);
    status.iterLast  = (iterCnt == LastIter);
  end

  // R5: the child never runs past its last body step
  p_child_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    childCnt <= LastStep);

endmodule

// File: rtl/sched_control.sv
module sched_control
  import repeat_sched_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  sched_status_t status,
  output sched_strobe_t strobe,
  output logic          active,
  output logic          done
);

  logic loopBusy;
  logic loopEnd;
  logic parentAdvance;

  always_comb begin
    loopBusy      = active && status.atOffload;
    loopEnd       = loopBusy && status.childWrap && status.iterLast;
    parentAdvance = active && (!status.atOffload || loopEnd);

    strobe.childInc  = loopBusy && !status.childWrap;
    strobe.childClr  = loopBusy && status.childWrap;
    strobe.iterInc   = loopBusy && status.childWrap && !status.iterLast;
    strobe.iterClr   = loopEnd;
    strobe.parentInc = parentAdvance && !status.atLast;
    strobe.finish    = parentAdvance && status.atLast;
    strobe.parentClr = strobe.finish;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.finish)      active <= 1'b0;
      else if (start)         active <= 1'b1;
    end
  end

  // R7: done never lasts longer than one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: an idle start always launches
  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && start) |=> active);

endmodule

// File: rtl/repeat_sched.sv
module repeat_sched
  import repeat_sched_pkg::*;
#(
  parameter int PARENT_LEN = 21,
  parameter int OFFLOAD_AT = 5,
  parameter int BODY_LAT   = 5,
  parameter int REPEATS    = 10,
  localparam int PW = cntWidth(PARENT_LEN),
  localparam int CW = cntWidth(BODY_LAT),
  localparam int IW = cntWidth(REPEATS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          done,
  output logic          active,
  output logic [PW-1:0] parentState,
  output logic [CW-1:0] childStep,
  output logic [IW-1:0] iterIdx
);

  localparam logic [PW-1:0] OffState  = PW'(OFFLOAD_AT);
  localparam logic [PW-1:0] LastState = PW'(PARENT_LEN - 1);
  localparam logic [CW-1:0] LastStep  = CW'(BODY_LAT - 1);
  localparam logic [IW-1:0] LastIter  = IW'(REPEATS - 1);

  sched_strobe_t strobe;
  sched_status_t status;

  sched_control ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .status(status), .strobe(strobe), .active(active), .done(done)
  );

  sched_datapath #(
    .PARENT_LEN(PARENT_LEN), .OFFLOAD_AT(OFFLOAD_AT),
    .BODY_LAT(BODY_LAT), .REPEATS(REPEATS)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .parentCnt(parentState), .childCnt(childStep), .iterCnt(iterIdx)
  );

  // R3: plain parent states step by one
  p_parent_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && parentState != OffState && parentState != LastState)
    |=> parentState == $past(parentState) + PW'(1));

  // R4: parent frozen while the loop is not at its exit
  p_parent_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && parentState == OffState &&
     !(childStep == LastStep && iterIdx == LastIter))
    |=> parentState == OffState);

  // R5: a non-final wrap bumps the iteration count
  p_child_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && parentState == OffState && childStep == LastStep &&
     iterIdx != LastIter)
    |=> (childStep == '0 && iterIdx == $past(iterIdx) + IW'(1)));

  // R6: loop exit clears the loop counters and resumes the parent together
  p_loop_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && parentState == OffState && childStep == LastStep &&
     iterIdx == LastIter && OffState != LastState)
    |=> (childStep == '0 && iterIdx == '0 && parentState == OffState + PW'(1)));

  // R9: loop counters rest at zero outside the offload
  p_loop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!active || parentState != OffState) |-> (childStep == '0 && iterIdx == '0));

  // R7: done arrives with everything back at rest
  p_done_rest_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!active && parentState == '0));

endmodule

// File: tb/repeat_sched_test.sv
module repeat_sched_test;

  localparam int PLEN = 21;
  localparam int OFF  = 5;
  localparam int BL   = 5;
  localparam int REP  = 10;
  localparam int TOTAL = (PLEN - 1) + BL * REP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic done, active;
  logic [4:0] parentState;
  logic [2:0] childStep;
  logic [3:0] iterIdx;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  repeat_sched #(.PARENT_LEN(PLEN), .OFFLOAD_AT(OFF), .BODY_LAT(BL), .REPEATS(REP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .active(active),
    .parentState(parentState), .childStep(childStep), .iterIdx(iterIdx)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expParent(input int t);
    if (t < OFF) return t;
    if (t < OFF + BL * REP) return OFF;
    return t - BL * REP + 1;
  endfunction

  function automatic int expChild(input int t);
    if (t >= OFF && t < OFF + BL * REP) return (t - OFF) % BL;
    return 0;
  endfunction

  function automatic int expIter(input int t);
    if (t >= OFF && t < OFF + BL * REP) return (t - OFF) / BL;
    return 0;
  endfunction

  task automatic test_reset();
    check("R1", active, 0, "active after reset");
    check("R1", done, 0, "done after reset");
    check("R1", parentState, 0, "parent after reset");
    check("R1", childStep + iterIdx, 0, "loop counters after reset");
  endtask

  // Runs one full schedule; pokes start at cycles where poke[t] is set (R8).
  task automatic run_schedule(input string tag, input bit [TOTAL-1:0] poke);
    string rq;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", active, 1, {tag, " active after launch"});
    for (int t = 0; t < TOTAL; t++) begin
      rq = (poke != '0) ? "R8" : (t < OFF) ? "R3" :
           (t < OFF + BL * REP) ? "R5" : (t == OFF + BL * REP) ? "R6" : "R3";
      check(rq, parentState, expParent(t), $sformatf("%s parent t=%0d", tag, t));
      check(rq == "R3" ? "R9" : rq, childStep, expChild(t), $sformatf("%s child t=%0d", tag, t));
      check(rq == "R3" ? "R9" : rq, iterIdx, expIter(t), $sformatf("%s iter t=%0d", tag, t));
      if (t > OFF && t < OFF + BL * REP)
        check("R4", parentState, OFF, $sformatf("%s parent frozen t=%0d", tag, t));
      check("R7", done, 0, $sformatf("%s early done t=%0d", tag, t));
      start = poke[t];
      @(negedge clk);
      start = 1'b0;
    end
    check("R7", done, 1, {tag, " done at final count"});
    check("R7", active, 0, {tag, " active drops with done"});
    check("R7", parentState + childStep + iterIdx, 0, {tag, " counters at rest"});
    @(negedge clk);
    check("R7", done, 0, {tag, " done one cycle only"});
    check("R1", active, 0, {tag, " stays idle"});
  endtask

  task automatic test_plain();
    run_schedule("plain", '0);
  endtask

  task automatic test_retrigger();
    bit [TOTAL-1:0] p = '0;
    p[1] = 1'b1;
    p[OFF + 7] = 1'b1;
    p[OFF + BL * REP - 1] = 1'b1;
    p[TOTAL - 1] = 1'b1;
    run_schedule("retrigger", p);
  endtask

  task automatic test_idle_hold();
    repeat (3) @(negedge clk);
    check("R9", childStep + iterIdx, 0, "idle loop counters");
    check("R1", parentState, 0, "idle parent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_plain();
    test_idle_hold();
    test_retrigger();
    test_plain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule